// File: doc/BRIEF.md
# Wide-Bus Cycle Initiator for Foreign Masters

This block runs one 32-bit bus cycle on the wide system bus for a master that does not own that bus. The master is either the host processor or a 16-bit narrow-bus master. A request is accepted only while the block is idle. At that point the block captures the cycle attributes:

- which side is requesting,
- memory or I/O,
- read or write,
- the byte lanes.

It then drives a one-clock address phase, marked by an active-low start strobe. A command phase follows, marked by an active-low command strobe, and lasts until the addressed slave reports ready.

For a host master, the host byte enables pass straight through. For a narrow master, the byte enables are formed from its two lowest address bits and its byte-high enable. While the host holds its lock input, the block drives the bus lock line. A host stretch input can hold the command phase open. Ready is ignored in a stretched clock, so that clock is not spent as a wait state. When the block is idle, all driven lines are deasserted and the output enable is low, so another master can drive them.

Top module: `wide_cycle_initiator`

## Requirements
- R1: When idle (after reset and between cycles), `start_n_o`=1, `cmd_n_o`=1, `be_n_o`=4'hF, `mio_o`=0, `wr_o`=0 and `oe_o`=0.
- R2: If `req_i` is high at a rising edge while idle, the cycle is accepted. `start_n_o` is then low for exactly the next clock, with `cmd_n_o` high in that clock.
- R3: `cmd_n_o` goes low in the clock after `start_n_o` and stays low. It returns high in the clock after the first edge at which `rdy_i`=1 and `stretch_i`=0. Each edge with `rdy_i`=0 adds one wait clock.
- R4: At an edge in the command phase with `stretch_i`=1, `rdy_i` is ignored and the command phase continues.
- R5: `done_o` is high for exactly one clock: the clock in which `cmd_n_o` returns high.
- R6: For a narrow master (`host_i`=0), the enabled lanes are set by `na_i`. `na_i[1]` picks lanes 1:0 (value 0) or lanes 3:2 (value 1). With `na_i[0]`=0 the even lane is enabled, and the odd lane is also enabled if `nbhe_n_i`=0. With `na_i[0]`=1 only the odd lane is enabled. `be_n_o` is the inverse of the lane enables.
- R7: For a host master (`host_i`=1), `be_n_o` equals the `hbe_n_i` value captured at acceptance.
- R8: From the start clock through the last command clock, `oe_o`=1, `mio_o`=`mem_i` and `wr_o`=`write_i`, all captured at acceptance. Later changes to the request inputs have no effect.
- R9: `lock_n_o` goes low with the start strobe of a host cycle accepted while `hlock_i`=1. It stays low while `hlock_i` stays high, including after the cycle ends. It returns high in the clock after an edge with `hlock_i`=0. A narrow-master cycle never asserts it.
- R10: `req_i` during a cycle starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request from a foreign master |
| host_i | input | 1 | 1 = host requester, 0 = narrow-bus requester |
| mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| write_i | input | 1 | 1 = write, 0 = read |
| hbe_n_i | input | 4 | Host byte enables, active low |
| na_i | input | 2 | Narrow-bus low address bits |
| nbhe_n_i | input | 1 | Narrow-bus byte-high enable, active low |
| hlock_i | input | 1 | Host lock request |
| rdy_i | input | 1 | Slave ready |
| stretch_i | input | 1 | Host stretch of the command phase |
| start_n_o | output | 1 | Address-phase strobe, active low |
| cmd_n_o | output | 1 | Command-phase strobe, active low |
| be_n_o | output | 4 | Wide-bus byte enables, active low |
| mio_o | output | 1 | Memory (1) or I/O (0) |
| wr_o | output | 1 | Write (1) or read (0) |
| lock_n_o | output | 1 | Bus lock, active low |
| oe_o | output | 1 | Drive enable for the cycle lines |
| done_o | output | 1 | One-clock completion pulse to the requester |

## Verification
A sequencer stuck in or skipping a phase shows up within one clock as a start strobe lasting longer or shorter than one clock, or as a command strobe that ignores ready or stretch. A bad completion register shows as `done_o` out of step with the rising edge of `cmd_n_o` in the same clock. Wrongly captured attributes show in the first address clock as a wrong byte-lane pattern or wrong cycle type. Corrupted attribute registers show as values changing while the command phase is held. A faulty lock register shows one clock after a lock change, or in the idle clocks after a locked cycle.

// File: rtl/wci_pkg.sv
package wci_pkg;
  parameter int unsigned BE_W = 4;
  localparam int unsigned LANE_SEL_W = $clog2(BE_W);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} seq_state_e;
endpackage

// File: rtl/wci_be_map.sv
module wci_be_map #(
  parameter int unsigned BW = wci_pkg::BE_W,
  parameter int unsigned LW = $clog2(BW)
) (
  input  logic          host_i,
  input  logic [BW-1:0] hbe_n_i,
  input  logic [LW-1:0] na_i,
  input  logic          nbhe_n_i,
  output logic [BW-1:0] be_n_o
);
  logic [BW-1:0] lane_en;

  // narrow master: na[LW-1:1] picks a lane pair, na[0] and byte-high pick within it
  for (genvar g = 0; g < BW; g++) begin : g_lane
    localparam int unsigned PAIR = g / 2;
    if (g % 2 == 0) begin : g_even
      assign lane_en[g] = (32'(na_i[LW-1:1]) == PAIR) && !na_i[0];
    end else begin : g_odd
      assign lane_en[g] = (32'(na_i[LW-1:1]) == PAIR) && (na_i[0] || !nbhe_n_i);
    end
  end

  assign be_n_o = host_i ? hbe_n_i : ~lane_en;
endmodule

// File: rtl/wci_seq.sv
module wci_seq
  import wci_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rdy_i,
  input  logic stretch_i,
  output logic accept_o,
  output logic busy_o,
  output logic start_n_o,
  output logic cmd_n_o,
  output logic done_o
);
  seq_state_e st_q, st_d;
  logic       done_q;
  logic       finish;

  assign finish = (st_q == ST_DATA) && rdy_i && !stretch_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if (finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  assign accept_o  = (st_q == ST_IDLE) && req_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign start_n_o = (st_q != ST_ADDR);
  assign cmd_n_o   = (st_q != ST_DATA);
  assign done_o    = done_q;

  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |=> (start_n_o && !cmd_n_o));
  a_r3_ready_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_n_o && rdy_i && !stretch_i) |=> cmd_n_o);
  a_r3_not_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_n_o && !rdy_i) |=> !cmd_n_o);
  a_r4_stretch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_n_o && stretch_i) |=> !cmd_n_o);
  a_r5_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_n_o && $past(!cmd_n_o)));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_n_o && req_i) |=> start_n_o);
endmodule

// File: rtl/wci_lock.sv
module wci_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic host_i,
  input  logic hlock_i,
  output logic lock_n_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lock_q <= 1'b0;
    else if (!hlock_i)           lock_q <= 1'b0;
    else if (accept_i && host_i) lock_q <= 1'b1;
  end

  assign lock_n_o = !lock_q;

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hlock_i |=> lock_n_o);
  a_r9_narrow_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !host_i && lock_n_o) |=> lock_n_o);
  a_r9_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_n_o && hlock_i) |=> !lock_n_o);
endmodule

// File: rtl/wide_cycle_initiator.sv
module wide_cycle_initiator #(
  parameter int unsigned BW = wci_pkg::BE_W,
  parameter int unsigned LW = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          host_i,
  input  logic          mem_i,
  input  logic          write_i,
  input  logic [BW-1:0] hbe_n_i,
  input  logic [LW-1:0] na_i,
  input  logic          nbhe_n_i,
  input  logic          hlock_i,
  input  logic          rdy_i,
  input  logic          stretch_i,
  output logic          start_n_o,
  output logic          cmd_n_o,
  output logic [BW-1:0] be_n_o,
  output logic          mio_o,
  output logic          wr_o,
  output logic          lock_n_o,
  output logic          oe_o,
  output logic          done_o
);
  logic          accept, busy;
  logic [BW-1:0] be_n_map, be_n_q;
  logic          mem_q, wr_q;

  wci_be_map #(.BW(BW), .LW(LW)) u_be_map (
    .host_i   (host_i),
    .hbe_n_i  (hbe_n_i),
    .na_i     (na_i),
    .nbhe_n_i (nbhe_n_i),
    .be_n_o   (be_n_map)
  );

  wci_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .rdy_i     (rdy_i),
    .stretch_i (stretch_i),
    .accept_o  (accept),
    .busy_o    (busy),
    .start_n_o (start_n_o),
    .cmd_n_o   (cmd_n_o),
    .done_o    (done_o)
  );

  wci_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .host_i   (host_i),
    .hlock_i  (hlock_i),
    .lock_n_o (lock_n_o)
  );

  // attributes frozen at acceptance for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_n_q <= '1;
      mem_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      be_n_q <= be_n_map;
      mem_q  <= mem_i;
      wr_q   <= write_i;
    end
  end

  assign oe_o   = busy;
  assign be_n_o = busy ? be_n_q : '1;
  assign mio_o  = busy && mem_q;
  assign wr_o   = busy && wr_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (start_n_o && cmd_n_o && (be_n_o == '1) && !mio_o && !wr_o));
  a_r8_attrs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !(!cmd_n_o && rdy_i && !stretch_i))
      |=> ($stable(be_n_o) && $stable(mio_o) && $stable(wr_o) && oe_o));
  a_r6_narrow_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !host_i) |=> ($countones(~be_n_o) inside {1, 2}));
endmodule

// File: tb/tb_wide_cycle_initiator.sv
module tb_wide_cycle_initiator;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 0, host_i = 0, mem_i = 0, write_i = 0, nbhe_n_i = 1;
  logic       hlock_i = 0, rdy_i = 0, stretch_i = 0;
  logic [3:0] hbe_n_i = 4'hF;
  logic [1:0] na_i = 2'b00;
  logic       start_n_o, cmd_n_o, mio_o, wr_o, lock_n_o, oe_o, done_o;
  logic [3:0] be_n_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  lock_exp = 0;

  always #4 clk_i = ~clk_i;

  wide_cycle_initiator dut (
    .clk_i, .rst_ni, .req_i, .host_i, .mem_i, .write_i, .hbe_n_i, .na_i,
    .nbhe_n_i, .hlock_i, .rdy_i, .stretch_i, .start_n_o, .cmd_n_o, .be_n_o,
    .mio_o, .wr_o, .lock_n_o, .oe_o, .done_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R6/R7 expected active-low lanes
  function automatic logic [3:0] exp_be(bit host, logic [3:0] hbe, logic [1:0] na, bit bhe_n);
    logic [3:0] en;
    if (host) return hbe;
    en = 4'b0000;
    if (!na[0]) begin
      en[{na[1], 1'b0}] = 1'b1;
      if (!bhe_n) en[{na[1], 1'b1}] = 1'b1;
    end else begin
      en[{na[1], 1'b1}] = 1'b1;
    end
    return ~en;
  endfunction

  task automatic chk_idle(input string tag);
    chk({tag, " start_n"}, start_n_o, 1);
    chk({tag, " cmd_n"}, cmd_n_o, 1);
    chk({tag, " be_n"}, be_n_o, 4'hF);
    chk({tag, " mio"}, mio_o, 0);
    chk({tag, " wr"}, wr_o, 0);
    chk({tag, " oe"}, oe_o, 0);
  endtask

  task automatic run_cyc(input bit host, input bit mem, input bit wr, input logic [3:0] hbe,
                         input logic [1:0] na, input bit bhe_n, input bit hlock,
                         input int nw, input bit st_first);
    logic [3:0] ebe;
    int  waits = nw;
    int  st_cnt = 0;
    bit  first = 1;
    bit  fin = 0;
    bit  prev_st = 0;
    @(negedge clk_i);
    req_i = 1; host_i = host; mem_i = mem; write_i = wr; hbe_n_i = hbe;
    na_i = na; nbhe_n_i = bhe_n; hlock_i = hlock; rdy_i = 0; stretch_i = 0;
    ebe = exp_be(host, hbe, na, bhe_n);
    @(posedge clk_i);
    lock_exp = (host && hlock) || (lock_exp && hlock);
    @(negedge clk_i);
    chk("R2 start_n", start_n_o, 0);
    chk("R2 cmd_n", cmd_n_o, 1);
    chk("R8 oe", oe_o, 1);
    chk(host ? "R7 be_n" : "R6 be_n", be_n_o, ebe);
    chk("R8 mio", mio_o, mem);
    chk("R8 wr", wr_o, wr);
    chk("R9 lock_n", lock_n_o, !lock_exp);
    // R8/R10: request inputs change mid-cycle and must be ignored
    req_i = 1; host_i = $urandom; mem_i = $urandom; write_i = $urandom;
    hbe_n_i = 4'($urandom); na_i = 2'($urandom); nbhe_n_i = $urandom;
    @(posedge clk_i);
    while (!fin) begin
      @(negedge clk_i);
      chk(prev_st ? "R4 cmd_n held" : "R3 cmd_n", cmd_n_o, 0);
      chk("R10 start_n", start_n_o, 1);
      chk("R5 done", done_o, 0);
      chk(host ? "R7 be_n" : "R6 be_n", be_n_o, ebe);
      chk("R8 mio", mio_o, mem);
      chk("R8 wr", wr_o, wr);
      chk("R8 oe", oe_o, 1);
      chk("R9 lock_n", lock_n_o, !lock_exp);
      if (first && st_first) begin
        stretch_i = 1; rdy_i = 1; prev_st = 1;
      end else if (st_cnt < 2 && ($urandom % 4) == 0) begin
        stretch_i = 1; rdy_i = $urandom; st_cnt++; prev_st = 1;
      end else if (waits > 0) begin
        stretch_i = 0; rdy_i = 0; waits--; prev_st = 0;
      end else begin
        stretch_i = 0; rdy_i = 1; req_i = 0; fin = 1; prev_st = 0;
      end
      first = 0;
      @(posedge clk_i);
    end
    @(negedge clk_i);
    chk("R5 done", done_o, 1);
    chk("R3 cmd_n released", cmd_n_o, 1);
    chk_idle("R1 after cycle");
    chk("R9 lock_n", lock_n_o, !lock_exp);
    rdy_i = 0; stretch_i = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 done single", done_o, 0);
    chk_idle("R1 between");
    chk("R9 lock_n after cycle", lock_n_o, !lock_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    chk_idle("R1 reset");
    chk("R1 done", done_o, 0);
    chk("R9 reset lock_n", lock_n_o, 1);
    rst_ni = 1;
    @(negedge clk_i);
    chk_idle("R1 post reset");

    // R6: every narrow lane combination, no waits
    for (int i = 0; i < 8; i++)
      run_cyc(0, i[0], i[1], 4'h0, 2'(i), i[2], 0, 0, 0);
    // R7: host passthrough with waits
    run_cyc(1, 1, 0, 4'b1010, 2'b00, 1, 0, 2, 0);
    run_cyc(1, 0, 1, 4'b0000, 2'b11, 0, 0, 0, 0);
    // R4: stretch with ready high must not end the cycle
    run_cyc(1, 1, 1, 4'b1100, 2'b00, 1, 0, 0, 1);
    run_cyc(0, 0, 1, 4'hF, 2'b10, 0, 0, 3, 1);
    // R9: locked host cycles, then release
    run_cyc(1, 1, 1, 4'b0011, 2'b00, 1, 1, 1, 0);
    run_cyc(0, 1, 0, 4'hF, 2'b01, 1, 1, 0, 0);
    @(negedge clk_i); hlock_i = 0;
    @(posedge clk_i); lock_exp = 0;
    @(negedge clk_i);
    chk("R9 release", lock_n_o, 1);
    // R9: narrow cycle with host lock high never locks
    run_cyc(0, 1, 1, 4'hF, 2'b00, 0, 1, 1, 0);
    chk("R9 narrow no lock", lock_n_o, 1);
    hlock_i = 0;

    for (int k = 0; k < 150; k++)
      run_cyc($urandom, $urandom, $urandom, 4'($urandom), 2'($urandom), $urandom,
              ($urandom % 3) == 0, $urandom % 4, ($urandom % 5) == 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule